// File: doc/BRIEF.md
# Self-Clocked Cascading Pixel Receiver

This block is one node of a daisy-chained string of colour pixel drivers that share a single data wire. Each node watches its serial input with its own free-running clock and never recovers timing from the incoming bit rate. Every bit begins with a rising edge. The node judges a bit by taking one sample of the line a fixed number of local cycles after that edge: a short high pulse reads as 0 and a long one reads as 1.

The first 24 bits after a reset, or after a latch, fill the node's own colour word. Every later bit is passed to the data output for the next node in the chain, with a fixed delay and with its pulse width set again by the node. A low period on the input that lasts long enough copies the shifted-in word to the colour output, raises a one-cycle strobe, and makes the node ready to take a new word.

Both serial pins and the colour strobe are plain signals with no handshake. The serial stream has no back-pressure: bits that arrive are decoded or lost, and nothing is ever held back. The colour output has no ready input either. A consumer must capture `color_q` in the cycle in which `color_vld` is high. The value on `color_q` then stays the same until the next strobe.

Top module: `pix_cascade_rx`

## Requirements
- R1: During and straight after reset, `dout` is 0, `color_vld` is 0 and `color_q` is all zeros.
- R2: A rising edge on `din` is accepted only if the node is armed. From an accepted rising edge, the bit value is the input level sampled `FWD_CYC + ZERO_HI_CYC` local cycles later (high = 1). While fewer than 24 bits are held, each value is shifted in MSB first. The first byte received (green) ends in `color_q[23:16]`, the second (red) in `color_q[15:8]` and the third (blue) in `color_q[7:0]`.
- R3: While the node is still filling its own 24-bit word, `dout` stays low.
- R4: Once 24 bits are held, `dout` rises `FWD_CYC + 3` local cycles after each accepted rising edge on `din`. This count includes the two-stage input synchroniser and the edge register.
- R5: A forwarded pulse is high for `ZERO_HI_CYC` cycles if the sampled bit is 0, and for `2*ZERO_HI_CYC` cycles if it is 1. The low time between forwarded pulses follows the input spacing.
- R6: A rising edge fewer than `MIN_BIT_CYC` cycles after the previous accepted rising edge is ignored and its bit is lost. A rising edge exactly `MIN_BIT_CYC` cycles later is accepted.
- R7: When the synchronised input stays low for `LATCH_CYC` consecutive cycles, the shift register is copied to `color_q` and `color_vld` goes high for one cycle. A low run of `LATCH_CYC - 1` cycles does nothing.
- R8: A latch clears the bit count. The bits that follow fill a new word and are not forwarded.
- R9: A long low with no bits received since reset or since the last latch gives no strobe.
- R10: If fewer than 24 bits arrived after a latch, the next latch copies the shift register as it stands: the earlier word moved up by the number of new bits, with the new bits in the low positions.
- R11: `color_q` changes only in a cycle in which `color_vld` is high, and `color_vld` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running local clock of the node |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 1 | Serial data from the previous node, asynchronous to clk |
| dout | output | 1 | Regenerated serial data for the next node |
| color_q | output | 24 | Latched colour word: green [23:16], red [15:8], blue [7:0] |
| color_vld | output | 1 | One-cycle strobe marking a new value on color_q |

## Verification
The bench builds the node with a forwarding delay of 4 cycles, a zero-pulse width of 6, a minimum bit spacing of 14 and a latch threshold of 60. These values keep a whole frame and its latch gap to a few hundred cycles, so one run can cover several frames. With a sample point at 10 cycles, the bench can place a glitch two cycles after the sample point and still inside the lock-out window. It can also send bits at exactly the minimum spacing, with a two-cycle low gap. Forwarded widths of 6 and 12 cycles, and a low run of 59 against 60, can be checked to the exact cycle.

// File: rtl/pix_rx_pkg.sv
`timescale 1ns/1ps
package pix_rx_pkg;
  localparam int unsigned PIX_BITS  = 24;
  localparam int unsigned PIX_CNT_W = $clog2(PIX_BITS + 1);

  // Field order follows arrival order: first byte in the top field.
  typedef struct packed {
    logic [7:0] grn;
    logic [7:0] red;
    logic [7:0] blu;
  } pix_word_t;
endpackage

// File: rtl/pix_sync_edge.sv
`timescale 1ns/1ps
// Brings the asynchronous serial input into the local clock domain and
// flags the cycle in which a low-to-high change becomes visible.
module pix_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  // pipe[STAGES-1] is the synchronised level; pipe[STAGES] is its
  // one-cycle-old copy used for edge detection.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/pix_bit_timer.sv
`timescale 1ns/1ps
// Per-bit timer driven by the node's own clock. An edge is accepted only
// when the previous bit is at least MIN_BIT_CYC cycles old; the timer then
// produces the forwarding strobe and the single sampling strobe.
module pix_bit_timer #(
  parameter int unsigned FWD_CYC     = 10,
  parameter int unsigned ZERO_HI_CYC = 18,
  parameter int unsigned MIN_BIT_CYC = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic start,
  output logic fwd_stb,
  output logic sample_stb
);
  localparam int unsigned SAMPLE_CYC = FWD_CYC + ZERO_HI_CYC;
  localparam int unsigned TW         = $clog2(MIN_BIT_CYC + 1);
  localparam logic [TW-1:0] T_FWD    = TW'(FWD_CYC);
  localparam logic [TW-1:0] T_SMP    = TW'(SAMPLE_CYC);
  localparam logic [TW-1:0] T_MIN    = TW'(MIN_BIT_CYC);

  logic [TW-1:0] age;     // cycles since the last accepted edge, saturating
  logic          primed;  // an edge has been accepted since reset
  logic          armed;

  assign armed = !primed || (age == T_MIN);
  assign start = rise && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age    <= '0;
      primed <= 1'b0;
    end else if (start) begin
      age    <= TW'(1);
      primed <= 1'b1;
    end else if (primed && age != T_MIN) begin
      age    <= age + TW'(1);
    end
  end

  assign fwd_stb    = primed && (age == T_FWD);
  assign sample_stb = primed && (age == T_SMP);
endmodule

// File: rtl/pix_word_capture.sv
`timescale 1ns/1ps
// Collects the node's own colour bits and latches them after a long low.
module pix_word_capture
  import pix_rx_pkg::*;
#(
  parameter int unsigned LATCH_CYC = 450
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level,
  input  logic      sample_stb,
  output logic      full,
  output pix_word_t color_q,
  output logic      color_vld
);
  localparam int unsigned LW          = $clog2(LATCH_CYC + 1);
  localparam logic [LW-1:0] LOW_SAT   = LW'(LATCH_CYC);
  localparam logic [LW-1:0] LOW_LAST  = LW'(LATCH_CYC - 1);
  localparam logic [PIX_CNT_W-1:0] WORD_N = PIX_CNT_W'(PIX_BITS);

  logic [PIX_BITS-1:0]  shreg;
  logic [PIX_CNT_W-1:0] taken;
  logic [LW-1:0]        low_run;
  logic                 latch_hit;

  assign full      = (taken == WORD_N);
  // Fires once per low run: the counter saturates past this value.
  assign latch_hit = !level && (low_run == LOW_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (level)          low_run <= '0;
    else if (low_run != LOW_SAT) low_run <= low_run + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      taken     <= '0;
      color_q   <= '0;
      color_vld <= 1'b0;
    end else begin
      color_vld <= 1'b0;
      if (latch_hit && taken != '0) begin
        color_q   <= pix_word_t'(shreg);
        color_vld <= 1'b1;
        taken     <= '0;
      end else if (sample_stb && !full) begin
        shreg <= {shreg[PIX_BITS-2:0], level};
        taken <= taken + PIX_CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pix_fwd_gen.sv
`timescale 1ns/1ps
// Rebuilds forwarded pulses: high at the forwarding strobe, set to the
// sampled value at the sampling strobe, and a sampled 1 held ZERO_HI_CYC more.
module pix_fwd_gen #(
  parameter int unsigned ZERO_HI_CYC = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic full,
  input  logic fwd_stb,
  input  logic sample_stb,
  input  logic level,
  output logic dout
);
  localparam int unsigned EW = $clog2(ZERO_HI_CYC + 1);
  localparam logic [EW-1:0] HOLD_N = EW'(ZERO_HI_CYC);

  logic          relay;  // the bit in flight belongs to the next node
  logic [EW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     relay <= 1'b0;
    else if (start) relay <= full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b0;
      hold <= '0;
    end else if (relay && fwd_stb) begin
      dout <= 1'b1;
    end else if (relay && sample_stb) begin
      dout <= level;
      hold <= level ? HOLD_N : '0;
    end else if (hold != '0) begin
      hold <= hold - EW'(1);
      if (hold == EW'(1)) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_cascade_rx.sv
`timescale 1ns/1ps
// One node of a single-wire cascaded pixel chain. All timing is given in
// local clock cycles; sampling happens FWD_CYC + ZERO_HI_CYC after an edge.
// MIN_BIT_CYC + FWD_CYC must exceed the sample point plus ZERO_HI_CYC.
module pix_cascade_rx #(
  parameter int unsigned FWD_CYC     = 10,
  parameter int unsigned ZERO_HI_CYC = 18,
  parameter int unsigned MIN_BIT_CYC = 38,
  parameter int unsigned LATCH_CYC   = 450,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        din,
  output logic        dout,
  output logic [23:0] color_q,
  output logic        color_vld
);
  import pix_rx_pkg::*;

  logic      lvl;
  logic      rise;
  logic      start;
  logic      fwd_stb;
  logic      sample_stb;
  logic      full;
  pix_word_t word_q;

  pix_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(din), .level(lvl), .rise(rise)
  );

  pix_bit_timer #(
    .FWD_CYC(FWD_CYC), .ZERO_HI_CYC(ZERO_HI_CYC), .MIN_BIT_CYC(MIN_BIT_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .rise(rise), .start(start),
    .fwd_stb(fwd_stb), .sample_stb(sample_stb)
  );

  pix_word_capture #(.LATCH_CYC(LATCH_CYC)) u_cap (
    .clk(clk), .rst_n(rst_n), .level(lvl), .sample_stb(sample_stb),
    .full(full), .color_q(word_q), .color_vld(color_vld)
  );

  pix_fwd_gen #(.ZERO_HI_CYC(ZERO_HI_CYC)) u_fwd (
    .clk(clk), .rst_n(rst_n), .start(start), .full(full),
    .fwd_stb(fwd_stb), .sample_stb(sample_stb), .level(lvl), .dout(dout)
  );

  assign color_q = word_q;
endmodule

// File: rtl/pix_cascade_rx_chk.sv
`timescale 1ns/1ps
module pix_cascade_rx_chk #(
  parameter int unsigned ZERO_HI_CYC = 18,
  parameter int unsigned MIN_BIT_CYC = 38,
  parameter int unsigned LATCH_CYC   = 450
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dout,
  input logic [23:0] color_q,
  input logic        color_vld,
  input logic        lvl,
  input logic        start,
  input logic        full
);
  localparam int unsigned HI_MAX = 2 * ZERO_HI_CYC;
  localparam int unsigned HW = $clog2(HI_MAX + 1);
  localparam int unsigned GW = $clog2(MIN_BIT_CYC + 1);
  localparam int unsigned LW = $clog2(LATCH_CYC + 1);

  logic [HW-1:0] hi_run;
  logic [GW-1:0] gap;
  logic          seen;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0; gap <= '0; seen <= 1'b0; low_run <= '0;
    end else begin
      if (!dout) hi_run <= '0;
      else if (hi_run != HW'(HI_MAX)) hi_run <= hi_run + HW'(1);
      if (start) begin gap <= GW'(1); seen <= 1'b1; end
      else if (gap != GW'(MIN_BIT_CYC)) gap <= gap + GW'(1);
      if (lvl) low_run <= '0;
      else if (low_run != LW'(LATCH_CYC)) low_run <= low_run + LW'(1);
    end
  end

  // R5
  fwd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout |-> (hi_run < HW'(HI_MAX)));
  // R6
  bit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && seen) |-> (gap >= GW'(MIN_BIT_CYC)));
  // R3
  fwd_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout) |-> full);
  // R7
  latch_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    color_vld |-> (low_run >= LW'(LATCH_CYC)));
  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    color_vld |=> !color_vld);
  // R11
  color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(color_q) |-> color_vld);
endmodule

bind pix_cascade_rx pix_cascade_rx_chk #(
  .ZERO_HI_CYC(ZERO_HI_CYC), .MIN_BIT_CYC(MIN_BIT_CYC), .LATCH_CYC(LATCH_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dout(dout), .color_q(color_q),
  .color_vld(color_vld), .lvl(lvl), .start(start), .full(full)
);

// File: tb/sim_pix_cascade_rx.sv
`timescale 1ns/1ps
module sim_pix_cascade_rx;
  localparam int FWD = 4;
  localparam int ZH  = 6;
  localparam int MNB = 14;
  localparam int LAT = 60;
  localparam int HI0 = 4;
  localparam int CLK_P = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        din = 1'b0;
  logic        dout;
  logic [23:0] color_q;
  logic        color_vld;

  int nchk = 0;
  int nerr = 0;
  int nvld = 0;
  int npulse = 0;
  int hrun = 0;
  logic dprev = 1'b0;
  logic [23:0] last_col = '0;
  int widths [0:127];
  time frise_t = 0;
  logic frise_arm = 1'b0;

  always #2.5 clk = ~clk;

  pix_cascade_rx #(
    .FWD_CYC(FWD), .ZERO_HI_CYC(ZH), .MIN_BIT_CYC(MNB), .LATCH_CYC(LAT), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .dout(dout),
    .color_q(color_q), .color_vld(color_vld)
  );

  // Output monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (color_vld) begin
      nvld++;
      last_col = color_q;
    end
    if (dout && !dprev && frise_arm) begin
      frise_t = $time;
      frise_arm = 1'b0;
    end
    if (dout) hrun++;
    else if (dprev) begin
      if (npulse < 128) widths[npulse] = hrun;
      npulse++;
      hrun = 0;
    end
    dprev = dout;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int period, input int hi1);
    int hi;
    hi = b ? hi1 : HI0;
    din = 1'b1;
    repeat (hi) @(negedge clk);
    din = 1'b0;
    repeat (period - hi) @(negedge clk);
  endtask

  task automatic send_word(input logic [23:0] w, input int period, input int hi1);
    for (int i = 23; i >= 0; i--) send_bit(w[i], period, hi1);
  endtask

  task automatic wait_low(input int n);
    din = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R1 dout", dout, 0);
    chk("R1 color_vld", color_vld, 0);
    chk("R1 color_q", color_q, 0);
  endtask

  task automatic test_idle();
    int v0;
    v0 = nvld;
    wait_low(3 * LAT);
    chk("R9 no strobe on idle low", nvld - v0, 0);
    chk("R9 no output on idle", npulse, 0);
  endtask

  task automatic test_capture();
    int v0, p0;
    v0 = nvld; p0 = npulse;
    send_word(24'hA53C0F, 24, 16);
    wait_low(LAT + 10);
    chk("R7 one strobe", nvld - v0, 1);
    chk("R2 colour word", last_col, 24'hA53C0F);
    chk("R2 green field", last_col[23:16], 8'hA5);
    chk("R2 blue field", last_col[7:0], 8'h0F);
    chk("R3 no forwarding while filling", npulse - p0, 0);
    wait_low(20);
    chk("R11 colour held", color_q, 24'hA53C0F);
  endtask

  task automatic test_forward();
    int p0, mism;
    time rt;
    logic [23:0] fw;
    fw = 24'h965AC3;
    p0 = npulse;
    send_word(24'h3C5AA5, 24, 16);
    rt = $time;
    frise_arm = 1'b1;
    send_word(fw, 24, 16);
    wait_low(LAT + 10);
    chk("R2 own word kept", last_col, 24'h3C5AA5);
    chk("R4 forwarded pulse count", npulse - p0, 24);
    chk("R4 forwarding delay", (frise_t - rt) / CLK_P, FWD + 3);
    mism = 0;
    for (int i = 0; i < 24; i++)
      if (widths[p0 + i] != (fw[23 - i] ? 2 * ZH : ZH)) mism++;
    chk("R5 forwarded widths", mism, 0);
    chk("R5 first width (1)", widths[p0], 2 * ZH);
    chk("R5 third width (0)", widths[p0 + 2], ZH);
  endtask

  task automatic test_fresh();
    int p0, v0;
    p0 = npulse; v0 = nvld;
    send_word(24'h12EDB7, 24, 16);
    wait_low(LAT + 10);
    chk("R8 new word after latch", last_col, 24'h12EDB7);
    chk("R8 strobe", nvld - v0, 1);
    chk("R8 new word not forwarded", npulse - p0, 0);
  endtask

  task automatic threshold_word(input int lowlen);
    logic [23:0] d;
    d = 24'h5AA53C;
    for (int i = 23; i >= 1; i--) send_bit(d[i], 24, 16);
    din = 1'b1;
    repeat (HI0) @(negedge clk);
    wait_low(lowlen);
    din = 1'b1;
    repeat (3) @(negedge clk);
    wait_low(3);
  endtask

  task automatic test_threshold();
    int v0;
    v0 = nvld;
    threshold_word(LAT - 1);
    chk("R7 short low does not latch", nvld - v0, 0);
    wait_low(LAT + 10);
    chk("R7 later latch", nvld - v0, 1);
    chk("R7 latched word", last_col, 24'h5AA53C);
    v0 = nvld;
    threshold_word(LAT);
    chk("R7 exact low latches", nvld - v0, 1);
    chk("R7 exact latch word", last_col, 24'h5AA53C);
    wait_low(LAT + 10);
    chk("R10 partial word strobe", nvld - v0, 2);
    chk("R10 partial word value", last_col, 24'hB54A78);
  endtask

  task automatic test_glitch();
    logic [23:0] e;
    e = 24'h0F00F0;
    for (int i = 23; i >= 0; i--) begin
      if (e[i]) send_bit(1'b1, 24, 16);
      else begin
        din = 1'b1; repeat (HI0) @(negedge clk);
        din = 1'b0; repeat (12 - HI0) @(negedge clk);
        din = 1'b1; @(negedge clk);
        din = 1'b0; repeat (11) @(negedge clk);
      end
    end
    wait_low(LAT + 10);
    chk("R6 close edges dropped", last_col, 24'h0F00F0);
  endtask

  task automatic test_minperiod();
    send_word(24'hC35A96, MNB, 12);
    wait_low(LAT + 10);
    chk("R6 edges at minimum spacing accepted", last_col, 24'hC35A96);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_idle();
    test_capture();
    test_forward();
    test_fresh();
    test_threshold();
    test_glitch();
    test_minperiod();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule